// File: doc/BRIEF.md
# Binary Input Conditioner

This block sits between the raw digital inputs of a protection relay and its protection logic. Each of up to sixteen channels is first brought into the system clock domain. It is then optionally inverted to suit a normally-open or normally-closed contact. Finally it is debounced by two independent timers: a pickup delay applied while the output is inactive, and a dropout delay applied while it is active. Both delays are counted in ticks of a millisecond enable pulse.

Each conditioned channel carries an assignment code that routes its level to one of several function outputs. Function output 0 is the Block1 signal, which holds off protection elements while any channel assigned to it is active. Every function output is the OR of all channels assigned to it. Delays, polarity and assignment codes are static configuration inputs.

Top module: `binary_input_conditioner`

## Requirements
- R1: After reset, every channel output and every function output is 0, and the delay counters start from zero.
- R2: Each raw input passes through two flip-flops before the timers see it. A raw change made at the same clock edge as a tick therefore has no effect at that tick.
- R3: When a channel's polarity bit is 1 (normally closed), the raw level is inverted before timing. When the bit is 0 (normally open), the raw level is used as it is.
- R4: An inactive channel output goes to 1 at the tick where the corrected input has been 1 for tON+1 consecutive ticks.
- R5: An active channel output goes to 0 at the tick where the corrected input has been 0 for tOFF+1 consecutive ticks.
- R6: If the corrected input returns to the output level during a pickup or dropout interval, that interval's count restarts from zero.
- R7: A delay of 0 makes the output follow the corrected input at the first tick after the change.
- R8: Channel outputs change only on a clock edge where the tick input is 1.
- R9: The assignment code of a channel selects its function output. Code 0 selects none. Code k (1..N_FUNC) drives func_out[k-1], and func_out[0] is Block1.
- R10: Each function output is 1 exactly when at least one channel assigned to it has an active output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle millisecond enable |
| raw_in | input | N_CH | Unsynchronised contact inputs |
| nc_sel | input | N_CH | Per-channel polarity, 1 = normally closed |
| t_on_flat | input | N_CH*DLY_W | Pickup delays in ticks, channel i at bits [i*DLY_W +: DLY_W] |
| t_off_flat | input | N_CH*DLY_W | Dropout delays in ticks, same packing |
| func_sel_flat | input | N_CH*SEL_W | Assignment codes, channel i at bits [i*SEL_W +: SEL_W] |
| chan_out | output | N_CH | Conditioned channel levels |
| func_out | output | N_FUNC | Function outputs, bit 0 = Block1 |

## Verification
A raw change needs two clock edges to clear the synchroniser. After that, a channel output moves at the clock edge that samples the deciding tick, and function outputs follow in the same cycle through combinational ORs. The bench therefore holds every raw change for at least two cycles before it issues a tick. It pushes each expectation only after the tick pulse has fallen, and it leaves inputs unchanged until the next negative edge. The monitor samples on negative edges, so each sample sees a settled state. One stimulus deliberately raises a raw input and a tick together to show the synchroniser latency.

// File: rtl/bic_pkg.sv
// Package: shared constants and types for the binary input conditioner.
// Assumes nothing beyond IEEE 1800-2017 packages.
package bic_pkg;
    localparam int MIN_CH = 8;
    localparam int MAX_CH = 16;

    typedef enum logic {
        POL_OPEN   = 1'b0,
        POL_CLOSED = 1'b1
    } pol_e;
endpackage

// File: rtl/bic_sync.sv
// Module: two-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherency is provided.
module bic_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    // Purpose: shift the raw inputs through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/bic_chan_timer.sv
// Module: pickup/dropout timer for one channel.
// The output moves to the corrected level once the level has differed
// from it on (delay+1) consecutive ticks. The delay is t_on while the
// output is low and t_off while it is high. Any cycle in which the input
// equals the output clears the count. Assumes the delays are static.
module bic_chan_timer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             lvl_in,
    input  logic [DLY_W-1:0] t_on,
    input  logic [DLY_W-1:0] t_off,
    output logic             lvl_out
);
    logic [DLY_W-1:0] cnt;
    logic [DLY_W-1:0] limit;

    // Purpose: pick the delay that applies to the pending transition.
    always_comb limit = lvl_out ? t_off : t_on;

    // Purpose: count qualifying ticks and flip the output at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_out <= 1'b0;
            cnt     <= '0;
        end else if (lvl_in == lvl_out) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == limit) begin
                lvl_out <= lvl_in;
                cnt     <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bic_func_router.sv
// Module: routes conditioned channel levels to function outputs.
// Code 0 = unassigned, code k drives function k-1; each function is the
// OR of its channels. Assumes codes above N_FUNC select nothing.
module bic_func_router #(
    parameter int N_CH   = 16,
    parameter int N_FUNC = 4,
    parameter int SEL_W  = 3
) (
    input  logic [N_CH-1:0]       lvl,
    input  logic [N_CH*SEL_W-1:0] sel_flat,
    output logic [N_FUNC-1:0]     func_out
);
    // Purpose: OR every channel into the function its code selects.
    always_comb begin
        func_out = '0;
        for (int f = 0; f < N_FUNC; f++) begin
            for (int ch = 0; ch < N_CH; ch++) begin
                if (lvl[ch] && (sel_flat[ch*SEL_W +: SEL_W] == SEL_W'(f + 1)))
                    func_out[f] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/binary_input_conditioner.sv
// Module: top of the binary input conditioner.
// Synchronises, applies polarity, times and routes N_CH contact inputs.
// Assumes tick_ms is a single-cycle pulse and all configuration is static.
module binary_input_conditioner
    import bic_pkg::*;
#(
    parameter int N_CH   = 16,
    parameter int DLY_W  = 16,
    parameter int N_FUNC = 4,
    parameter int SEL_W  = $clog2(N_FUNC + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_ms,
    input  logic [N_CH-1:0]       raw_in,
    input  logic [N_CH-1:0]       nc_sel,
    input  logic [N_CH*DLY_W-1:0] t_on_flat,
    input  logic [N_CH*DLY_W-1:0] t_off_flat,
    input  logic [N_CH*SEL_W-1:0] func_sel_flat,
    output logic [N_CH-1:0]       chan_out,
    output logic [N_FUNC-1:0]     func_out
);
    if (N_CH < MIN_CH || N_CH > MAX_CH) begin : g_bad_ch
        $error("N_CH out of supported range");
    end

    logic [N_CH-1:0] synced;
    logic [N_CH-1:0] corrected;

    bic_sync #(.W(N_CH)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .q_sync  (synced)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_chan
        // Purpose: invert normally-closed contacts.
        always_comb corrected[i] = synced[i] ^ (nc_sel[i] == POL_CLOSED);

        bic_chan_timer #(.DLY_W(DLY_W)) timer_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick_ms),
            .lvl_in  (corrected[i]),
            .t_on    (t_on_flat[i*DLY_W +: DLY_W]),
            .t_off   (t_off_flat[i*DLY_W +: DLY_W]),
            .lvl_out (chan_out[i])
        );
    end

    bic_func_router #(.N_CH(N_CH), .N_FUNC(N_FUNC), .SEL_W(SEL_W)) router_i (
        .lvl      (chan_out),
        .sel_flat (func_sel_flat),
        .func_out (func_out)
    );
endmodule

// File: rtl/bic_checker.sv
// Module: assertion checker bound to binary_input_conditioner.
// Observes ports only; assumes synchronous active-low reset.
module bic_checker #(
    parameter int N_CH   = 16,
    parameter int N_FUNC = 4,
    parameter int SEL_W  = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick_ms,
    input logic [N_CH-1:0]       chan_out,
    input logic [N_FUNC-1:0]     func_out,
    input logic [N_CH*SEL_W-1:0] func_sel_flat
);
    // R1: a reset cycle clears all outputs by the next edge.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (chan_out == '0 && func_out == '0));

    // R8: without a tick the channel outputs hold.
    p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_ms |=> $stable(chan_out));

    // R9: a function output cannot be active with no active channel.
    p_func_needs_chan_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (func_out != '0) |-> (chan_out != '0));

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        // R10: an active channel coded for Block1 forces Block1 high.
        p_block1_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_out[i] && func_sel_flat[i*SEL_W +: SEL_W] == SEL_W'(1))
            |-> func_out[0]);
    end
endmodule

bind binary_input_conditioner bic_checker #(
    .N_CH(N_CH), .N_FUNC(N_FUNC), .SEL_W(SEL_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_ms       (tick_ms),
    .chan_out      (chan_out),
    .func_out      (func_out),
    .func_sel_flat (func_sel_flat)
);

// File: tb/binary_input_conditioner_tb_top.sv
// Scoreboard bench: the driver pushes expected output states after each
// stimulus; a negedge monitor pops and compares them.
module binary_input_conditioner_tb_top;
    localparam int N_CH   = 16;
    localparam int DLY_W  = 16;
    localparam int N_FUNC = 4;
    localparam int SEL_W  = 3;

    typedef struct {
        string             tag;
        logic [N_CH-1:0]   ch;
        logic [N_FUNC-1:0] fn;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b0;
    logic [N_CH-1:0] raw_in = '0;
    logic [N_CH-1:0] nc_sel = '0;
    logic [N_CH*DLY_W-1:0] t_on_flat = '0;
    logic [N_CH*DLY_W-1:0] t_off_flat = '0;
    logic [N_CH*SEL_W-1:0] func_sel_flat = '0;
    logic [N_CH-1:0] chan_out;
    logic [N_FUNC-1:0] func_out;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [N_CH-1:0] e_ch = '0;
    logic [N_FUNC-1:0] e_fn = '0;

    always #5 clk = ~clk;

    binary_input_conditioner dut_i (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .raw_in(raw_in),
        .nc_sel(nc_sel), .t_on_flat(t_on_flat), .t_off_flat(t_off_flat),
        .func_sel_flat(func_sel_flat), .chan_out(chan_out), .func_out(func_out)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick1();
        @(negedge clk) tick_ms = 1'b1;
        @(negedge clk) tick_ms = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick1();
    endtask

    task automatic set_raw(input int i, input logic v);
        @(negedge clk) raw_in[i] = v;
        step(2);
    endtask

    task automatic expect_state(input string tag);
        exp_t it;
        it.tag = tag; it.ch = e_ch; it.fn = e_fn;
        q.push_back(it);
    endtask

    // Monitor: compare one pending expectation per negative edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            checks++;
            if (chan_out !== it.ch || func_out !== it.fn) begin
                errors++;
                $display("FAIL %s chan_out=%h exp=%h func_out=%h exp=%h",
                         it.tag, chan_out, it.ch, func_out, it.fn);
            end
        end
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog all requirements: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Config: ch0 on=3 off=2 Block1; ch1 zero delays func1; ch2 NC
        // on=1 off=1 Block1; ch3 zero delays unassigned.
        t_on_flat[0*DLY_W +: DLY_W]  = 16'd3;
        t_off_flat[0*DLY_W +: DLY_W] = 16'd2;
        t_on_flat[2*DLY_W +: DLY_W]  = 16'd1;
        t_off_flat[2*DLY_W +: DLY_W] = 16'd1;
        func_sel_flat[0*SEL_W +: SEL_W] = 3'd1;
        func_sel_flat[1*SEL_W +: SEL_W] = 3'd2;
        func_sel_flat[2*SEL_W +: SEL_W] = 3'd1;
        nc_sel[2] = 1'b1;
        raw_in[2] = 1'b1;

        step(5);
        expect_state("R1 during reset");
        @(negedge clk) rst_n = 1'b1;
        step(3);
        expect_state("R1 after release");
        tick1();
        expect_state("R1 counters clear");

        // R2: raw and tick raised together; tick sees the old level.
        @(negedge clk) begin raw_in[1] = 1'b1; tick_ms = 1'b1; end
        @(negedge clk) tick_ms = 1'b0;
        expect_state("R2 sync latency");
        step(2);
        tick1();
        e_ch[1] = 1'b1; e_fn[1] = 1'b1;
        expect_state("R7 zero pickup");

        // R8: no tick, no change.
        set_raw(3, 1'b1);
        step(20);
        expect_state("R8 hold without tick");
        tick1();
        e_ch[3] = 1'b1;
        expect_state("R9 unassigned channel");

        // R4: pickup on the fourth tick.
        set_raw(0, 1'b1);
        ticks(3);
        expect_state("R4 before pickup");
        tick1();
        e_ch[0] = 1'b1; e_fn[0] = 1'b1;
        expect_state("R4 pickup Block1");

        // R5/R6: dropout with a bounce.
        set_raw(0, 1'b0);
        ticks(2);
        expect_state("R5 before dropout");
        set_raw(0, 1'b1);
        step(1);
        set_raw(0, 1'b0);
        ticks(2);
        expect_state("R6 bounce restart");
        tick1();
        e_ch[0] = 1'b0; e_fn[0] = 1'b0;
        expect_state("R5 dropout");

        // R3: normally-closed channel picks up when raw goes low.
        set_raw(2, 1'b0);
        tick1();
        expect_state("R3 before pickup");
        tick1();
        e_ch[2] = 1'b1; e_fn[0] = 1'b1;
        expect_state("R3 inverted pickup");

        // R10: Block1 stays while another assigned channel is active.
        set_raw(0, 1'b1);
        ticks(4);
        e_ch[0] = 1'b1;
        expect_state("R10 two on Block1");
        set_raw(2, 1'b1);
        ticks(2);
        e_ch[2] = 1'b0;
        expect_state("R10 one of two dropped");
        set_raw(0, 1'b0);
        ticks(3);
        e_ch[0] = 1'b0; e_fn[0] = 1'b0;
        expect_state("R10 all dropped");

        // R7: zero dropout.
        set_raw(1, 1'b0);
        tick1();
        e_ch[1] = 1'b0; e_fn[1] = 1'b0;
        expect_state("R7 zero dropout");

        step(4);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule